// File: doc/BRIEF.md
# Transfer Slot Queue with Two-Group Launch

This control block sits between software and a block-copy data mover. Software stages a transfer (source address, destination address, length) in staging registers and then commits it with a write to a commit register. The commit moves the staged descriptor into a free slot of a small in-order queue. A status register reports how many slots are free. Each committed slot carries a group tag, 0 or 1. After reset the tag is group 0. A launch write for one group switches the tag to the other group, so software can prepare the second batch while the first one runs.

Slots leave the queue strictly in commit order. The head slot is offered to the data mover only after its group has been launched. The request interface is valid/ready. When `req_valid` is high and `req_ready` is low, the payload stays frozen until the mover accepts it. Only one transfer is in flight at a time, and the mover ends it with a one-cycle `cmp_valid` pulse. A slot is counted as free again only on that completion, not when it is issued.

When every transfer of a launched group has completed, the block sets that group's sticky pending bit. Software clears the bit by writing one to it. Each group has a mask bit that gates its interrupt pin. Each group also has a read-stall counter and a write-stall counter. A counter advances on each cycle its group's transfer is in flight with the matching stall input high, but only while profiling is enabled. Both counters of a group clear when that group is launched.

Top module: `xfer_slot_launcher`

## Requirements
- R1: After reset the free count equals SLOTS (4), the pending and interrupt bits are 0, `req_valid` is 0 and all stall counters read 0.
- R2: A write of bit 0 = 1 to offset 3 commits the staged registers (offset 0 source, 1 destination, 2 length) into a slot and lowers the free count (offset 6, bits [7:0]) by one. A commit while the free count is 0 is ignored.
- R3: Slots are offered to the mover in commit order. While `req_valid` is high and `req_ready` is low, the request payload and `req_valid` hold unchanged.
- R4: A slot is not offered before its group is launched. A write of bit 0 = 1 to offset 4 launches group 0, and to offset 5 launches group 1.
- R5: Commits after reset are tagged group 0. A launch of group g makes later commits carry tag 1-g, which is seen on `req_grp`.
- R6: The free count rises by one only on a completion pulse. Issuing a slot does not change it, and it never exceeds SLOTS.
- R7: When a launched group has no committed-but-uncompleted transfers, its pending bit (offset 7, bit g) sets. A launch with nothing committed sets it within two cycles.
- R8: Pending bits stay set until a write of one to the same bit of offset 7. `irq[g]` = pending[g] AND mask[g], where the mask is at offset 8, bit g, with a reset value of 1.
- R9: With offset 9 bit 0 set, the stall counters count cycles in which a transfer of their group is in flight and the stall input is high. The counters are at offset 10 (group 0 read), 11 (group 0 write), 12 (group 1 read) and 13 (group 1 write). With the bit clear, they hold.
- R10: A launch of group g clears both stall counters of group g.
- R11: After an accepted request, `req_valid` stays low until the completion pulse for that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| req_valid | output | 1 | Transfer request offered to the mover |
| req_ready | input | 1 | Mover accepts the request |
| req_src | output | 32 | Source address of the offered transfer |
| req_dst | output | 32 | Destination address of the offered transfer |
| req_len | output | 32 | Length of the offered transfer |
| req_grp | output | 1 | Group tag of the offered transfer |
| cmp_valid | input | 1 | One-cycle pulse ending the in-flight transfer |
| rd_stall | input | 1 | Mover stalled on read this cycle |
| wr_stall | input | 1 | Mover stalled on write this cycle |
| irq | output | 2 | Per-group done interrupts after masking |

## Verification
The bench fills the queue and then commits once more. A design that accepted that extra commit would issue a fifth transfer or corrupt the free count. It checks the free count in the cycle right after an issue, which catches a design that frees a slot on issue instead of on completion. It launches a group with nothing committed: a design that waits for a completion would never raise the pending bit. It also runs back-to-back groups with varied ready delays, which exposes a wrong group tag after a launch, an out-of-order issue, a payload that changes under back-pressure, and stall counts that leak into the other group or advance while profiling is off.

// File: rtl/xsl_pkg.sv
package xsl_pkg;
  localparam int NGRP = 2;

  typedef enum logic [3:0] {
    RA_SRC     = 4'd0,
    RA_DST     = 4'd1,
    RA_LEN     = 4'd2,
    RA_COMMIT  = 4'd3,
    RA_LAUNCH0 = 4'd4,
    RA_LAUNCH1 = 4'd5,
    RA_FREE    = 4'd6,
    RA_IRQ     = 4'd7,
    RA_MASK    = 4'd8,
    RA_PROF    = 4'd9,
    RA_G0RD    = 4'd10,
    RA_G0WR    = 4'd11,
    RA_G1RD    = 4'd12,
    RA_G1WR    = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/xsl_slot_fifo.sv
module xsl_slot_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push && !full) wr_ptr <= bump(wr_ptr);
      if (pop && !empty) rd_ptr <= bump(rd_ptr);
      case ({push && !full, pop && !empty})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/xsl_group_track.sv
module xsl_group_track #(
  parameter int SLOTS = 4,
  parameter int CNT_W = 32,
  localparam int OW   = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_i,
  input  logic             finish_i,
  input  logic             launch_i,
  input  logic             clr_i,
  input  logic             stall_en_i,
  input  logic             rd_hit_i,
  input  logic             wr_hit_i,
  output logic             launched_o,
  output logic             pending_o,
  output logic [OW-1:0]    outst_o,
  output logic [CNT_W-1:0] rd_cnt_o,
  output logic [CNT_W-1:0] wr_cnt_o
);
  logic drained;
  assign drained = launched_o && (outst_o == '0) && !commit_i && !launch_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst_o <= '0;
    end else begin
      case ({commit_i, finish_i})
        2'b10:   outst_o <= outst_o + 1'b1;
        2'b01:   outst_o <= outst_o - 1'b1;
        default: outst_o <= outst_o;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launched_o <= 1'b0;
      pending_o  <= 1'b0;
    end else begin
      if (launch_i)     launched_o <= 1'b1;
      else if (drained) launched_o <= 1'b0;
      if (drained)      pending_o  <= 1'b1;
      else if (clr_i)   pending_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || launch_i) begin
      rd_cnt_o <= '0;
      wr_cnt_o <= '0;
    end else if (stall_en_i) begin
      if (rd_hit_i && !(&rd_cnt_o)) rd_cnt_o <= rd_cnt_o + 1'b1;
      if (wr_hit_i && !(&wr_cnt_o)) wr_cnt_o <= wr_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/xfer_slot_launcher.sv
module xfer_slot_launcher
  import xsl_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int CNT_W  = 32,
  localparam int DESC_W = 2 * ADDR_W + LEN_W + 1,
  localparam int FREE_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_src,
  output logic [ADDR_W-1:0] req_dst,
  output logic [LEN_W-1:0]  req_len,
  output logic              req_grp,
  input  logic              cmp_valid,
  input  logic              rd_stall,
  input  logic              wr_stall,
  output logic [NGRP-1:0]   irq
);
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              cur_grp, prof_en, busy, busy_grp;
  logic [NGRP-1:0]   mask_q;

  logic [DESC_W-1:0] head;
  logic [FREE_W-1:0] q_count, free_cnt;
  logic              q_empty, q_full, do_push, do_pop, finish, commit_wr;
  logic [NGRP-1:0]   launch_wr, irq_clr, launched, pending;
  logic [NGRP-1:0][FREE_W-1:0] outst;
  logic [NGRP-1:0][CNT_W-1:0]  rd_cnt, wr_cnt;

  assign commit_wr    = reg_we && (reg_addr == RA_COMMIT) && reg_wdata[0];
  assign launch_wr[0] = reg_we && (reg_addr == RA_LAUNCH0) && reg_wdata[0];
  assign launch_wr[1] = reg_we && (reg_addr == RA_LAUNCH1) && reg_wdata[0];
  assign free_cnt     = FREE_W'(SLOTS) - q_count - FREE_W'(busy);
  assign do_push      = commit_wr && (free_cnt != '0);
  assign finish       = busy && cmp_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      cur_grp <= 1'b0;
      mask_q  <= '1;
      prof_en <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_SRC:  src_q   <= ADDR_W'(reg_wdata);
          RA_DST:  dst_q   <= ADDR_W'(reg_wdata);
          RA_LEN:  len_q   <= LEN_W'(reg_wdata);
          RA_MASK: mask_q  <= reg_wdata[NGRP-1:0];
          RA_PROF: prof_en <= reg_wdata[0];
          default: ;
        endcase
      end
      if (launch_wr[0])      cur_grp <= 1'b1;
      else if (launch_wr[1]) cur_grp <= 1'b0;
    end
  end

  xsl_slot_fifo #(.DEPTH(SLOTS), .W(DESC_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (do_push),
    .din   ({src_q, dst_q, len_q, cur_grp}),
    .pop   (do_pop),
    .dout  (head),
    .count (q_count),
    .empty (q_empty),
    .full  (q_full)
  );

  assign {req_src, req_dst, req_len, req_grp} = head;
  assign req_valid = !busy && !q_empty && launched[req_grp];
  assign do_pop    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_grp <= 1'b0;
    end else if (do_pop) begin
      busy     <= 1'b1;
      busy_grp <= req_grp;
    end else if (finish) begin
      busy     <= 1'b0;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic mine;
    assign mine       = busy && (busy_grp == 1'(g));
    assign irq_clr[g] = reg_we && (reg_addr == RA_IRQ) && reg_wdata[g];

    xsl_group_track #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .commit_i   (do_push && (cur_grp == 1'(g))),
      .finish_i   (finish && (busy_grp == 1'(g))),
      .launch_i   (launch_wr[g]),
      .clr_i      (irq_clr[g]),
      .stall_en_i (prof_en),
      .rd_hit_i   (mine && rd_stall),
      .wr_hit_i   (mine && wr_stall),
      .launched_o (launched[g]),
      .pending_o  (pending[g]),
      .outst_o    (outst[g]),
      .rd_cnt_o   (rd_cnt[g]),
      .wr_cnt_o   (wr_cnt[g])
    );
    assign irq[g] = pending[g] && mask_q[g];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SRC:  reg_rdata = DATA_W'(src_q);
      RA_DST:  reg_rdata = DATA_W'(dst_q);
      RA_LEN:  reg_rdata = DATA_W'(len_q);
      RA_FREE: reg_rdata = DATA_W'(free_cnt);
      RA_IRQ:  reg_rdata = DATA_W'(pending);
      RA_MASK: reg_rdata = DATA_W'(mask_q);
      RA_PROF: reg_rdata = DATA_W'(prof_en);
      RA_G0RD: reg_rdata = DATA_W'(rd_cnt[0]);
      RA_G0WR: reg_rdata = DATA_W'(wr_cnt[0]);
      RA_G1RD: reg_rdata = DATA_W'(rd_cnt[1]);
      RA_G1WR: reg_rdata = DATA_W'(wr_cnt[1]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/xfer_slot_launcher_chk.sv
module xfer_slot_launcher_chk #(
  parameter int SLOTS  = 4,
  parameter int FREE_W = 3,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic [LEN_W-1:0]  req_len,
  input logic              req_grp,
  input logic              cmp_valid,
  input logic [FREE_W-1:0] free_cnt,
  input logic [1:0]        launched,
  input logic [1:0]        pending
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_src) && $stable(req_dst)
                                   && $stable(req_len) && $stable(req_grp)));

  assert_launch_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> launched[req_grp]);

  assert_one_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_valid);

  assert_full_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 4'd3 && reg_wdata[0] && free_cnt == '0 && !cmp_valid)
      |=> (free_cnt == '0));

  assert_free_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FREE_W'(SLOTS));

  assert_done_g0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending[0]) |-> $past(launched[0]));

  assert_done_g1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending[1]) |-> $past(launched[1]));

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[0] && !(reg_we && reg_addr == 4'd7 && reg_wdata[0])) |=> pending[0]);
endmodule

bind xfer_slot_launcher xfer_slot_launcher_chk #(
  .SLOTS(SLOTS), .FREE_W(FREE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_src   (req_src),
  .req_dst   (req_dst),
  .req_len   (req_len),
  .req_grp   (req_grp),
  .cmp_valid (cmp_valid),
  .free_cnt  (free_cnt),
  .launched  (launched),
  .pending   (pending)
);

// File: tb/xfer_slot_launcher_bench.sv
`timescale 1ns/1ps
module xfer_slot_launcher_bench;
  localparam int SLOTS = 4;
  localparam int LAT   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid, req_grp;
  logic        req_ready = 1'b0;
  logic [31:0] req_src, req_dst, req_len;
  logic        cmp_valid = 1'b0;
  logic        rd_stall = 1'b0;
  logic        wr_stall = 1'b0;
  logic [1:0]  irq;

  int tests = 0;
  int fails = 0;
  int mv_delay = 0;
  int hold_err = 0;
  int log_n = 0;
  logic [31:0] log_src [16];
  logic        log_grp [16];

  always #4 clk = ~clk;

  xfer_slot_launcher u_xfer_slot_launcher (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_src(req_src), .req_dst(req_dst),
    .req_len(req_len), .req_grp(req_grp), .cmp_valid(cmp_valid),
    .rd_stall(rd_stall), .wr_stall(wr_stall), .irq(irq)
  );

  // vector: n0 [11:8], n1 [7:4], ready delay [3:0]
  localparam logic [11:0] VEC [4] = '{12'h220, 12'h132, 12'h301, 12'h020};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic commit(input logic [31:0] s);
    wr(4'd0, s);
    wr(4'd1, s + 32'h1000);
    wr(4'd2, 32'd64);
    wr(4'd3, 32'd1);
  endtask

  task automatic wait_pend(input logic [1:0] m);
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(4'd7, v);
      if ((v[1:0] & m) == m) break;
    end
  endtask

  // data mover model
  initial begin
    logic [31:0] first;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        first = req_src;
        for (int i = 0; i < mv_delay; i++) begin
          @(negedge clk);
          if (req_src !== first || !req_valid) hold_err++;
        end
        req_ready = 1'b1;
        log_src[log_n % 16] = req_src;
        log_grp[log_n % 16] = req_grp;
        @(posedge clk);
        @(negedge clk);
        req_ready = 1'b0;
        log_n++;
        for (int i = 0; i < LAT - 1; i++) @(negedge clk);
        cmp_valid = 1'b1;
        @(negedge clk);
        cmp_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int base, n0, n1, ok, i0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'd6, v);  chk(v == SLOTS, "R1 free after reset", v, SLOTS);
    rd(4'd7, v);  chk(v == 0 && irq == 0, "R1 pending after reset", v, 0);
    chk(req_valid == 1'b0, "R1 req_valid after reset", req_valid, 0);
    rd(4'd10, v); chk(v == 0, "R1 stall counter after reset", v, 0);

    // vector table
    foreach (VEC[k]) begin
      n0 = int'(VEC[k][11:8]); n1 = int'(VEC[k][7:4]);
      mv_delay = int'(VEC[k][3:0]);
      base = log_n; hold_err = 0;
      for (int i = 0; i < n0; i++) commit(32'h100 * k + i);
      wr(4'd4, 32'd1);
      for (int i = 0; i < n1; i++) commit(32'h100 * k + 8 + i);
      wr(4'd5, 32'd1);
      wait_pend(2'b11);
      rd(4'd7, v);  chk(v[1:0] == 2'b11, "R7 both groups done", v, 3);
      chk(log_n - base == n0 + n1, "R3 issue count", log_n - base, n0 + n1);
      ok = 1;
      for (int i = 0; i < n0 + n1; i++) begin
        i0 = (i < n0) ? i : 8 + i - n0;
        if (log_src[(base + i) % 16] != 32'h100 * k + i0) ok = 0;
        if (log_grp[(base + i) % 16] != ((i < n0) ? 1'b0 : 1'b1)) ok = 0;
      end
      chk(ok == 1, "R3 R5 order and group tags", ok, 1);
      chk(hold_err == 0, "R3 payload hold under back-pressure", hold_err, 0);
      rd(4'd6, v);  chk(v == SLOTS, "R6 free restored", v, SLOTS);
      wr(4'd7, 32'd3);
      rd(4'd7, v);  chk(v == 0, "R8 write-one clear", v, 0);
    end
    mv_delay = 0;

    // no issue before launch; free count drops (cur group is 0 again)
    base = log_n;
    commit(32'hA0); commit(32'hA1);
    repeat (5) @(negedge clk);
    chk(req_valid == 1'b0, "R4 no request before launch", req_valid, 0);
    rd(4'd6, v);  chk(v == 2, "R2 free after two commits", v, 2);
    commit(32'hA2); commit(32'hA3); commit(32'hA4);
    rd(4'd6, v);  chk(v == 0, "R2 commit when full ignored", v, 0);
    wr(4'd4, 32'd1);
    wait_pend(2'b01);
    chk(log_n - base == 4, "R2 only four transfers issued", log_n - base, 4);
    rd(4'd6, v);  chk(v == SLOTS, "R6 free after full group", v, SLOTS);
    wr(4'd7, 32'd3);

    // one in flight; slot not freed on issue (cur group 1)
    base = log_n;
    commit(32'hB0); commit(32'hB1);
    wr(4'd5, 32'd1);
    while (log_n == base) @(negedge clk);
    #1;
    chk(req_valid == 1'b0, "R11 no request while in flight", req_valid, 0);
    rd(4'd6, v);  chk(v == 2, "R6 free unchanged by issue", v, 2);
    wait_pend(2'b10);
    wr(4'd7, 32'd3);

    // stall profiling on group 0
    wr(4'd9, 32'd1);
    rd_stall = 1'b1;
    commit(32'hC0); commit(32'hC1);
    wr(4'd4, 32'd1);
    wait_pend(2'b01);
    rd(4'd10, v); chk(v == 2 * LAT, "R9 group0 read stalls", v, 2 * LAT);
    rd(4'd11, v); chk(v == 0, "R9 group0 write stalls", v, 0);
    rd(4'd12, v); chk(v == 0, "R9 group1 untouched", v, 0);
    wr(4'd9, 32'd0);
    commit(32'hC2);
    wr(4'd5, 32'd1);
    wait_pend(2'b10);
    rd(4'd12, v); chk(v == 0, "R9 no count when disabled", v, 0);
    rd_stall = 1'b0;
    wr(4'd7, 32'd3);

    // zero-transfer launch of group 0 clears its counters and completes
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = 32'd1;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 4'd7;
    @(negedge clk);
    #1 chk(reg_rdata[0] == 1'b1, "R7 empty launch completes", reg_rdata[0], 1);
    rd(4'd10, v); chk(v == 0, "R10 launch clears counter", v, 0);

    // mask and stickiness on group 1
    wr(4'd7, 32'd3);
    wr(4'd8, 32'd1);
    wr(4'd5, 32'd1);
    wait_pend(2'b10);
    chk(irq[1] == 1'b0, "R8 masked interrupt low", irq[1], 0);
    wr(4'd8, 32'd3);
    #1 chk(irq[1] == 1'b1, "R8 unmasked interrupt high", irq[1], 1);
    repeat (10) @(negedge clk);
    chk(irq[1] == 1'b1, "R8 pending sticky", irq[1], 1);
    wr(4'd7, 32'd2);
    #1 chk(irq == 2'b00, "R8 cleared", irq, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule